// File: doc/BRIEF.md
# Inter-Core Event Interrupt Controller

This block sits between a local processor and a peer core and carries doorbell interrupts for up to 32 mailbox channels. Software on the local core rings a peer channel by writing a bit with the channel's vector number into a peer doorbell register. That bit stays pending on a dedicated output line until the peer side retires it through its own clear input.

In the other direction, acknowledge and receive events arriving on a 32-bit event input are latched on their rising edge into a pending register. They are qualified by a per-vector enable mask and merged into a single registered interrupt line for the local core. An interrupt handler reads the qualified status, identifies each set bit as one channel, and retires serviced events by writing ones to a clear register. The enable mask can be loaded whole, or single vectors can be switched on and off through separate set and clear aliases, so no read-modify-write is needed. The choice of which vector to service first is left entirely to software.

The register bus is a plain strobe interface: a write takes effect on the clock edge that samples it, and read data appears on `bus_rdata` at the edge that samples the read strobe and holds until the next read.

Top module: `ipc_evt_ctrl`

## Requirements
- R1: After reset the pending, enable and doorbell registers are all zero, `local_irq` and `peer_irq` are low, and `bus_rdata` reads zero.
- R2: A 0-to-1 transition on bit n of `evt_in` sets bit n of the pending register (offset 0x400). A level held high does not set the bit again once it has been cleared.
- R3: Writing ones to offset 0x40C clears the matching pending bits, and zero bits leave their pending bits alone. If a rising event and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: A write to offset 0x404 replaces every enable bit with the written value, and a read of 0x404 returns the current enable bits. A value of 0 disables all vectors.
- R5: Writing ones to offset 0x500 sets the matching enable bits, and writing ones to offset 0x504 clears them. Zero bits have no effect, and both offsets read as zero.
- R6: A read of offset 0x408 returns the pending register ANDed with the enable bits.
- R7: `local_irq` is a register. It is high one cycle after any enabled pending bit exists, and low one cycle after none exists.
- R8: Writing ones to offset 0x420 sets the matching doorbell bits, which drive `peer_irq` directly. Zero bits have no effect, and a read of 0x420 returns the pending doorbell bits.
- R9: A one on bit n of `peer_clear` clears doorbell bit n. If a doorbell write and a peer clear hit the same bit in the same cycle, the bit ends up set.
- R10: `bus_rdata` updates only on a cycle that samples `bus_rd_en` and otherwise holds its value. Unmapped offsets read zero, and writes to offsets 0x400 and 0x408 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_in | input | 32 | Local acknowledge/receive events, one per vector |
| peer_clear | input | 32 | Peer-side retirement of doorbell bits |
| peer_irq | output | 32 | Pending doorbell interrupts toward the peer |
| local_irq | output | 1 | Combined interrupt toward the local core |

## Verification
The assertions assume that each write strobe lasts exactly one cycle. They also assume that `evt_in` and `peer_clear` are synchronous to `clk`, so that an event pulse spans at least one sampling edge and a falling edge is seen before the next rise. The stimulus changes every input only on the falling clock edge. It holds each event pulse, bus strobe and peer clear for exactly one full cycle, and it returns `evt_in` to zero before reusing a bit, except in the one case that deliberately holds a level high.

// File: rtl/ipc_evt_pkg.sv
package ipc_evt_pkg;

    localparam int unsigned REG_ADDR_W = 12;
    localparam int unsigned REG_DATA_W = 32;

    // Register offsets the software driver decodes
    localparam logic [15:0] OFF_PEND    = 16'h0400;
    localparam logic [15:0] OFF_MASK    = 16'h0404;
    localparam logic [15:0] OFF_STAT    = 16'h0408;
    localparam logic [15:0] OFF_PCLR    = 16'h040C;
    localparam logic [15:0] OFF_ENSET   = 16'h0500;
    localparam logic [15:0] OFF_ENCLR   = 16'h0504;
    localparam logic [15:0] OFF_DOORBELL = 16'h0420;

    typedef struct packed {
        logic mask_we;
        logic pclr_we;
        logic enset_we;
        logic enclr_we;
        logic bell_we;
    } wr_stb_t;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_PEND,
        RS_MASK,
        RS_STAT,
        RS_BELL
    } rd_sel_e;

endpackage

// File: rtl/ipc_evt_decode.sv
module ipc_evt_decode
    import ipc_evt_pkg::*;
#(
    parameter int unsigned ADDR_W = REG_ADDR_W
) (
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    output wr_stb_t           wr_stb,
    output rd_sel_e           rd_sel
);

    localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFF_PEND);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFF_MASK);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_PCLR  = ADDR_W'(OFF_PCLR);
    localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(OFF_ENSET);
    localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(OFF_ENCLR);
    localparam logic [ADDR_W-1:0] A_BELL  = ADDR_W'(OFF_DOORBELL);

    // Write strobes: pending and status are read-only, so no strobe exists
    always_comb begin
        wr_stb          = '0;
        wr_stb.mask_we  = bus_wr_en && (bus_addr == A_MASK);
        wr_stb.pclr_we  = bus_wr_en && (bus_addr == A_PCLR);
        wr_stb.enset_we = bus_wr_en && (bus_addr == A_ENSET);
        wr_stb.enclr_we = bus_wr_en && (bus_addr == A_ENCLR);
        wr_stb.bell_we  = bus_wr_en && (bus_addr == A_BELL);
    end

    // Read select: write-only aliases and unmapped offsets read zero
    always_comb begin
        rd_sel = RS_NONE;
        if (bus_rd_en) begin
            if (bus_addr == A_PEND)      rd_sel = RS_PEND;
            else if (bus_addr == A_MASK) rd_sel = RS_MASK;
            else if (bus_addr == A_STAT) rd_sel = RS_STAT;
            else if (bus_addr == A_BELL) rd_sel = RS_BELL;
            else                         rd_sel = RS_NONE;
        end
    end

endmodule

// File: rtl/ipc_evt_ack_bank.sv
module ipc_evt_ack_bank #(
    parameter int unsigned NCH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt_in,
    input  logic           mask_we,
    input  logic           pclr_we,
    input  logic           enset_we,
    input  logic           enclr_we,
    input  logic [NCH-1:0] wbits,
    output logic [NCH-1:0] pend_o,
    output logic [NCH-1:0] en_o,
    output logic [NCH-1:0] status_o,
    output logic           irq_o
);

    typedef struct packed {
        logic [NCH-1:0] pend;
        logic [NCH-1:0] en;
        logic [NCH-1:0] evt_prev;
        logic           irq;
    } ack_state_t;

    ack_state_t st_d, st_q;

    logic [NCH-1:0] rise;
    logic [NCH-1:0] pend_next;

    // Per-vector cell: edge detect, then set-over-clear priority
    for (genvar c = 0; c < NCH; c++) begin : g_vec
        assign rise[c]      = evt_in[c] & ~st_q.evt_prev[c];
        assign pend_next[c] = rise[c] | (st_q.pend[c] & ~(pclr_we & wbits[c]));
    end

    always_comb begin
        st_d          = st_q;
        st_d.evt_prev = evt_in;
        st_d.pend     = pend_next;
        if (mask_we) begin
            st_d.en = wbits;
        end else if (enset_we) begin
            st_d.en = st_q.en | wbits;
        end else if (enclr_we) begin
            st_d.en = st_q.en & ~wbits;
        end
        st_d.irq = |(st_q.pend & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o   = st_q.pend;
    assign en_o     = st_q.en;
    assign status_o = st_q.pend & st_q.en;
    assign irq_o    = st_q.irq;

    p_rise_latches_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pend_o & $past(rise)) == $past(rise)));

    p_no_spurious_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o & ~$past(pend_o) & ~$past(rise)) == '0);

    p_clear_retires_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pclr_we |=> ((pend_o & $past(wbits & ~rise)) == '0));

    p_mask_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (en_o == $past(wbits)));

    p_enset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        enset_we |=> ((en_o & $past(wbits)) == $past(wbits)));

    p_enclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        enclr_we |=> ((en_o & $past(wbits)) == '0));

    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o == '0) |=> !irq_o);

    p_irq_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != '0) |=> irq_o);

endmodule

// File: rtl/ipc_evt_peer_bank.sv
module ipc_evt_peer_bank #(
    parameter int unsigned NCH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bell_we,
    input  logic [NCH-1:0] wbits,
    input  logic [NCH-1:0] peer_clear,
    output logic [NCH-1:0] bell_o
);

    typedef struct packed {
        logic [NCH-1:0] bell;
    } peer_state_t;

    peer_state_t st_d, st_q;

    logic [NCH-1:0] bell_next;

    // Per-vector doorbell: a local ring wins over a same-cycle peer retire
    for (genvar c = 0; c < NCH; c++) begin : g_bell
        assign bell_next[c] = (bell_we & wbits[c]) | (st_q.bell[c] & ~peer_clear[c]);
    end

    always_comb begin
        st_d      = st_q;
        st_d.bell = bell_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bell_o = st_q.bell;

    p_bell_rings_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bell_we |=> ((bell_o & $past(wbits)) == $past(wbits)));

    p_bell_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bell_o & ~$past(bell_o) & ~($past(wbits) & {NCH{$past(bell_we)}})) == '0);

    p_peer_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((peer_clear != '0) && !bell_we) |=> ((bell_o & $past(peer_clear)) == '0));

endmodule

// File: rtl/ipc_evt_ctrl.sv
module ipc_evt_ctrl
    import ipc_evt_pkg::*;
#(
    parameter int unsigned NCH    = 32,
    parameter int unsigned ADDR_W = REG_ADDR_W,
    parameter int unsigned DATA_W = REG_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    evt_in,
    input  logic [NCH-1:0]    peer_clear,
    output logic [NCH-1:0]    peer_irq,
    output logic              local_irq
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    wr_stb_t        wr_stb;
    rd_sel_e        rd_sel;
    logic [NCH-1:0] wbits;
    logic [NCH-1:0] pend;
    logic [NCH-1:0] en;
    logic [NCH-1:0] status;
    logic [NCH-1:0] bell;

    rd_state_t rd_d, rd_q;

    assign wbits = bus_wdata[NCH-1:0];

    ipc_evt_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_addr  (bus_addr),
        .wr_stb    (wr_stb),
        .rd_sel    (rd_sel)
    );

    ipc_evt_ack_bank #(
        .NCH (NCH)
    ) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (evt_in),
        .mask_we  (wr_stb.mask_we),
        .pclr_we  (wr_stb.pclr_we),
        .enset_we (wr_stb.enset_we),
        .enclr_we (wr_stb.enclr_we),
        .wbits    (wbits),
        .pend_o   (pend),
        .en_o     (en),
        .status_o (status),
        .irq_o    (local_irq)
    );

    ipc_evt_peer_bank #(
        .NCH (NCH)
    ) u_peer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bell_we    (wr_stb.bell_we),
        .wbits      (wbits),
        .peer_clear (peer_clear),
        .bell_o     (bell)
    );

    // Read-back register: loads only when a read is sampled
    always_comb begin
        rd_d = rd_q;
        if (bus_rd_en) begin
            case (rd_sel)
                RS_PEND: rd_d.rdata = DATA_W'(pend);
                RS_MASK: rd_d.rdata = DATA_W'(en);
                RS_STAT: rd_d.rdata = DATA_W'(status);
                RS_BELL: rd_d.rdata = DATA_W'(bell);
                default: rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;
    assign peer_irq  = bell;

    p_rdata_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rdata));

    p_status_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && rd_sel == RS_STAT) |=> ((bus_rdata & ~DATA_W'($past(en))) == '0));

endmodule

// File: tb/tb_ipc_evt_ctrl.sv
`timescale 1ns/1ps
module tb_ipc_evt_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] evt_in = '0;
    logic [31:0] peer_clear = '0;
    logic [31:0] peer_irq;
    logic        local_irq;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    ipc_evt_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr_en  (bus_wr_en),
        .bus_rd_en  (bus_rd_en),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .evt_in     (evt_in),
        .peer_clear (peer_clear),
        .peer_irq   (peer_irq),
        .local_irq  (local_irq)
    );

    // kind: 0 write, 1 read and compare, 2 event pulse, 3 peer clear pulse
    typedef struct packed {
        logic [1:0]  kind;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 27;
    localparam vec_t TBL [0:NVEC-1] = '{
        '{2'd1, 12'h404, 32'h0,          32'h0,          4'd1},  // R1
        '{2'd1, 12'h400, 32'h0,          32'h0,          4'd1},  // R1
        '{2'd2, 12'h000, 32'h0000_00F1,  32'h0,          4'd2},  // R2
        '{2'd1, 12'h400, 32'h0,          32'h0000_00F1,  4'd2},  // R2
        '{2'd1, 12'h408, 32'h0,          32'h0,          4'd6},  // R6
        '{2'd0, 12'h404, 32'h0000_0011,  32'h0,          4'd4},  // R4
        '{2'd1, 12'h404, 32'h0,          32'h0000_0011,  4'd4},  // R4
        '{2'd1, 12'h408, 32'h0,          32'h0000_0011,  4'd6},  // R6
        '{2'd0, 12'h500, 32'h8000_0020,  32'h0,          4'd5},  // R5
        '{2'd1, 12'h404, 32'h0,          32'h8000_0031,  4'd5},  // R5
        '{2'd0, 12'h504, 32'h0000_0001,  32'h0,          4'd5},  // R5
        '{2'd1, 12'h404, 32'h0,          32'h8000_0030,  4'd5},  // R5
        '{2'd1, 12'h408, 32'h0,          32'h0000_0030,  4'd6},  // R6
        '{2'd0, 12'h40C, 32'h0000_0020,  32'h0,          4'd3},  // R3
        '{2'd1, 12'h400, 32'h0,          32'h0000_00D1,  4'd3},  // R3
        '{2'd1, 12'h408, 32'h0,          32'h0000_0010,  4'd6},  // R6
        '{2'd0, 12'h420, 32'h0000_0004,  32'h0,          4'd8},  // R8
        '{2'd0, 12'h420, 32'h0100_0000,  32'h0,          4'd8},  // R8
        '{2'd1, 12'h420, 32'h0,          32'h0100_0004,  4'd8},  // R8
        '{2'd3, 12'h000, 32'h0000_0004,  32'h0,          4'd9},  // R9
        '{2'd1, 12'h420, 32'h0,          32'h0100_0000,  4'd9},  // R9
        '{2'd0, 12'h400, 32'hFFFF_FFFF,  32'h0,          4'd10}, // R10
        '{2'd1, 12'h400, 32'h0,          32'h0000_00D1,  4'd10}, // R10
        '{2'd1, 12'h123, 32'h0,          32'h0,          4'd10}, // R10
        '{2'd1, 12'h500, 32'h0,          32'h0,          4'd5},  // R5
        '{2'd0, 12'h40C, 32'hFFFF_FFFF,  32'h0,          4'd3},  // R3
        '{2'd1, 12'h400, 32'h0,          32'h0,          4'd3}   // R3
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic evt_pulse(input logic [31:0] v);
        @(negedge clk);
        evt_in = v;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic pclr_pulse(input logic [31:0] v);
        @(negedge clk);
        peer_clear = v;
        @(negedge clk);
        peer_clear = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state at the ports
        chk("R1 local_irq", {31'b0, local_irq}, 32'h0);
        chk("R1 peer_irq", peer_irq, 32'h0);
        chk("R1 bus_rdata", bus_rdata, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            case (TBL[i].kind)
                2'd0: bus_write(TBL[i].addr, TBL[i].data);
                2'd1: begin
                    bus_read(TBL[i].addr, rd);
                    chk($sformatf("R%0d row %0d", TBL[i].req, i), rd, TBL[i].expv);
                end
                2'd2: evt_pulse(TBL[i].data);
                default: pclr_pulse(TBL[i].data);
            endcase
        end

        // R7: registered interrupt, one cycle behind the pending/enable state
        evt_pulse(32'h8000_0000);
        chk("R7 irq one cycle late", {31'b0, local_irq}, 32'h0);
        @(negedge clk);
        chk("R7 irq asserted", {31'b0, local_irq}, 32'h1);
        bus_write(12'h40C, 32'h8000_0000);
        chk("R7 irq still high after clear edge", {31'b0, local_irq}, 32'h1);
        @(negedge clk);
        chk("R7 irq dropped", {31'b0, local_irq}, 32'h0);

        // R2: a held level does not set the bit again after a clear
        @(negedge clk);
        evt_in = 32'h0000_0002;
        @(negedge clk);
        bus_write(12'h40C, 32'h0000_0002);
        bus_read(12'h400, rd);
        chk("R2 held level no reset", rd, 32'h0);
        @(negedge clk);
        evt_in = '0;

        // R3: rising event and clear on the same bit in one cycle
        @(negedge clk);
        evt_in = 32'h0000_0008;
        bus_wr_en = 1'b1; bus_addr = 12'h40C; bus_wdata = 32'h0000_0008;
        @(negedge clk);
        evt_in = '0; bus_wr_en = 1'b0; bus_wdata = '0;
        bus_read(12'h400, rd);
        chk("R3 set wins over clear", rd, 32'h0000_0008);
        bus_write(12'h40C, 32'h0000_0008);

        // R8: zero bits of a doorbell write leave pending bells alone
        bus_write(12'h420, 32'h0);
        chk("R8 zero write no effect", peer_irq, 32'h0100_0000);

        // R9: doorbell write and peer clear on the same bit
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 12'h420; bus_wdata = 32'h0000_0010;
        peer_clear = 32'h0000_0010;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0; peer_clear = '0;
        chk("R9 ring wins over retire", peer_irq, 32'h0100_0010);
        pclr_pulse(32'hFFFF_FFFF);
        chk("R9 peer clear all", peer_irq, 32'h0);

        // R4: mask value of 0 disables every vector
        bus_write(12'h404, 32'h0);
        bus_read(12'h404, rd);
        chk("R4 mask zero readback", rd, 32'h0);
        evt_pulse(32'h0000_0030);
        @(negedge clk);
        chk("R4 no irq with mask zero", {31'b0, local_irq}, 32'h0);
        bus_read(12'h408, rd);
        chk("R6 status zero with mask zero", rd, 32'h0);

        // R10: read data holds without a read strobe
        bus_write(12'h404, 32'h0000_0005);
        chk("R10 rdata holds", bus_rdata, 32'h0);
        bus_read(12'h404, rd);
        chk("R10 rdata after read", rd, 32'h0000_0005);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule